// File: doc/BRIEF.md
# Asymmetric SCL Phase Generator

This block derives the serial clock of a two-wire bus master from a fast system clock. Two independent 8-bit phase counts set the high and low parts of the SCL period, so both the frequency and the duty cycle can be tuned. The nominal reference runs at 48 MHz. The reset value of 185 clocks per phase gives a period of about 370 reference clocks.

The master's state machine raises `enable` to run the clock and drops it to park SCL high. A one-cycle `soft_rst` forces the generator back to idle. It leaves the programmed phase counts untouched. Each phase count is written through a plain register write port. Alongside the SCL level, the block emits one-cycle strobes on the cycles where SCL rises and falls, and the bit engine uses these to time data changes and sampling. All pins are plain control and status signals; there is no streaming interface, so no back-pressure applies.

Top module: `sclk_phase_gen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `scl` is 1 and both strobes are 0. Both phase counts reset to 185 (0xB9), so an unprogrammed run has 185 low cycles and then 185 high cycles.
- R2: A clock edge with `cfg_wr`=1 stores `cfg_data` into the low-phase count when `cfg_sel`=0, and into the high-phase count when `cfg_sel`=1.
- R3: While running, each low phase lasts exactly as many clock cycles as the low count, and each high phase lasts as many cycles as the high count.
- R4: A count of 0 behaves as a count of 1, so a phase is never shorter than one cycle.
- R5: From idle, the first clock edge that samples `enable`=1 (with `soft_rst`=0) drives `scl` low. The low phase therefore always comes first.
- R6: `fall_stb` is 1 exactly in the first cycle of each low level of `scl`. `rise_stb` is 1 exactly in the first cycle of each high level that follows a low level. The two strobes are never 1 together.
- R7: An edge that samples `enable`=0 returns `scl` to 1 and clears the phase counter. `scl` then stays high with no fall strobe until `enable` is seen high again.
- R8: An edge that samples `soft_rst`=1 sends the generator to idle with `scl`=1, even if `enable` is 1. The programmed phase counts are kept, and if `enable` stays 1 the next edge starts a fresh low phase.
- R9: A count written during a phase does not change the length of that phase. It applies from the next phase of the same kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request from the master state machine |
| soft_rst | input | 1 | One-cycle return to idle; counts are kept |
| cfg_wr | input | 1 | Phase-count write strobe |
| cfg_sel | input | 1 | Write target: 0 low count, 1 high count |
| cfg_data | input | 8 | Phase count to store |
| scl | output | 1 | Serial clock level |
| rise_stb | output | 1 | One-cycle pulse on the first high cycle |
| fall_stb | output | 1 | One-cycle pulse on the first low cycle |

## Verification
Every result is due one clock edge after the input that causes it. An edge that sees `enable` or `soft_rst` changes `scl` and the strobes at once. A written count is in place one edge after `cfg_wr`, and it shapes only phases that begin after that. Inputs are driven, and outputs sampled, on the falling clock edge. Counting from the first falling-edge sample after the start, sample i is compared with a timeline of low and high segments. The bench computes that timeline from the written counts, with a count of 0 taken as 1. Writes made in the middle of a phase are placed at known sample indices, so the expected segment lengths show exactly where a new count takes hold.

// File: rtl/scg_pkg.sv
package scg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  localparam logic SEL_LOW  = 1'b0;
  localparam logic SEL_HIGH = 1'b1;
endpackage

// File: rtl/scg_count_regs.sv
module scg_count_regs #(
  parameter int          DIV_W   = 8,
  parameter logic [DIV_W-1:0] RST_VAL = 8'hB9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             sel,
  input  logic [DIV_W-1:0] data,
  output logic [DIV_W-1:0] lo_cnt,
  output logic [DIV_W-1:0] hi_cnt
);
  import scg_pkg::*;

  // soft reset is deliberately not an input: counts survive it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= RST_VAL;
      hi_cnt <= RST_VAL;
    end else if (wr) begin
      if (sel == SEL_LOW) lo_cnt <= data;
      else                hi_cnt <= data;
    end
  end
endmodule

// File: rtl/scg_phase_fsm.sv
module scg_phase_fsm #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] lo_cnt,
  input  logic [DIV_W-1:0] hi_cnt,
  output logic             level_nxt
);
  import scg_pkg::*;

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  phase_e           phase_q, phase_d;
  logic [DIV_W-1:0] left_q, left_d;
  logic [DIV_W-1:0] lo_term, hi_term;

  // a zero count is stretched to one cycle; remaining = count - 1
  always_comb begin
    lo_term = (lo_cnt == '0) ? '0 : lo_cnt - ONE;
    hi_term = (hi_cnt == '0) ? '0 : hi_cnt - ONE;
  end

  always_comb begin
    phase_d = phase_q;
    left_d  = left_q;
    if (!run) begin
      phase_d = PH_IDLE;
      left_d  = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_d = PH_LOW;
          left_d  = lo_term;
        end
        PH_LOW: begin
          if (left_q == '0) begin
            phase_d = PH_HIGH;
            left_d  = hi_term;
          end else begin
            left_d = left_q - ONE;
          end
        end
        PH_HIGH: begin
          if (left_q == '0) begin
            phase_d = PH_LOW;
            left_d  = lo_term;
          end else begin
            left_d = left_q - ONE;
          end
        end
        default: begin
          phase_d = PH_IDLE;
          left_d  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      left_q  <= '0;
    end else begin
      phase_q <= phase_d;
      left_q  <= left_d;
    end
  end

  assign level_nxt = (phase_d != PH_LOW);
endmodule

// File: rtl/scg_edge_out.sv
module scg_edge_out (
  input  logic clk,
  input  logic rst_n,
  input  logic level_nxt,
  output logic scl,
  output logic rise_stb,
  output logic fall_stb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl      <= 1'b1;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
    end else begin
      scl      <= level_nxt;
      rise_stb <= level_nxt & ~scl;
      fall_stb <= ~level_nxt & scl;
    end
  end
endmodule

// File: rtl/sclk_phase_gen.sv
module sclk_phase_gen #(
  parameter int               DIV_W   = 8,
  parameter logic [DIV_W-1:0] RST_VAL = 8'hB9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             soft_rst,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [DIV_W-1:0] cfg_data,
  output logic             scl,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] lo_cnt, hi_cnt;
  logic             run;
  logic             level_nxt;

  assign run = enable & ~soft_rst;

  scg_count_regs #(.DIV_W(DIV_W), .RST_VAL(RST_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .data(cfg_data),
    .lo_cnt(lo_cnt), .hi_cnt(hi_cnt)
  );

  scg_phase_fsm #(.DIV_W(DIV_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .run(run), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt),
    .level_nxt(level_nxt)
  );

  scg_edge_out u_out (
    .clk(clk), .rst_n(rst_n), .level_nxt(level_nxt),
    .scl(scl), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );
endmodule

// File: rtl/scg_checker.sv
module scg_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic soft_rst,
  input logic scl,
  input logic rise_stb,
  input logic fall_stb
);
  p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (scl && !fall_stb));

  p_srst_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (scl && !fall_stb));

  p_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(enable) && !soft_rst) |=> !scl);

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));

  p_fall_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl) |-> fall_stb);

  p_fall_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> $fell(scl));

  p_rise_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl) |-> rise_stb);

  p_rise_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> $rose(scl));
endmodule

bind sclk_phase_gen scg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst(soft_rst),
  .scl(scl), .rise_stb(rise_stb), .fall_stb(fall_stb)
);

// File: tb/sim_sclk_phase_gen.sv
`timescale 1ns/1ps
module sim_sclk_phase_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       soft_rst = 1'b0;
  logic       cfg_wr = 1'b0;
  logic       cfg_sel = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic       scl, rise_stb, fall_stb;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  sclk_phase_gen u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst(soft_rst),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .scl(scl), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  function automatic int eff(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  // level at sample i: first pair l1/h1, then l2/h2 repeating
  function automatic bit exp_lvl(input int i, input int l1, input int h1,
                                 input int l2, input int h2);
    int j;
    if (i < 0) return 1'b1;
    if (i < l1) return 1'b0;
    if (i < l1 + h1) return 1'b1;
    j = (i - l1 - h1) % (l2 + h2);
    return (j < l2) ? 1'b0 : 1'b1;
  endfunction

  task automatic check_at(input int i, input int l1, input int h1,
                          input int l2, input int h2, input string tag);
    bit es, er, ef;
    es = exp_lvl(i, l1, h1, l2, h2);
    ef = !es && exp_lvl(i - 1, l1, h1, l2, h2);
    er = es && !exp_lvl(i - 1, l1, h1, l2, h2);
    total++;
    if (scl !== es || rise_stb !== er || fall_stb !== ef) begin
      bad++;
      $display("FAIL %s i=%0d scl=%b/%b rise=%b/%b fall=%b/%b",
               tag, i, scl, es, rise_stb, er, fall_stb, ef);
    end
  endtask

  task automatic check_idle(input bit exp_rise, input string tag);
    total++;
    if (scl !== 1'b1 || rise_stb !== exp_rise || fall_stb !== 1'b0) begin
      bad++;
      $display("FAIL %s idle scl=%b/1 rise=%b/%b fall=%b/0",
               tag, scl, rise_stb, exp_rise, fall_stb);
    end
  endtask

  task automatic write_cnt(input bit sel, input int val);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_data = 8'(val);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // enable at a falling edge, then compare n samples with the timeline
  task automatic run_periodic(input int lo, input int hi, input int n,
                              input string tag);
    enable = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_at(i, eff(lo), eff(hi), eff(lo), eff(hi), tag);
    end
  endtask

  task automatic stop_run();
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5CA1_0C1C));
    repeat (3) @(negedge clk);
    check_idle(1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle(1'b0, "R1 after reset");

    // R1/R5: defaults of 185 per phase, low first
    run_periodic(185, 185, 372, "R1 default 0xB9 period");
    stop_run();

    // R2/R3: programmed asymmetric counts
    write_cnt(1'b0, 4);
    write_cnt(1'b1, 9);
    run_periodic(4, 9, 30, "R2 R3 lo=4 hi=9");
    stop_run();

    // R4: zero counts behave as one
    write_cnt(1'b0, 0);
    write_cnt(1'b1, 0);
    run_periodic(0, 0, 8, "R4 lo=0 hi=0");
    stop_run();
    write_cnt(1'b0, 1);
    write_cnt(1'b1, 255);
    run_periodic(1, 255, 520, "R3 lo=1 hi=255");
    stop_run();

    // R9: mid-phase writes apply to the following phase of that kind
    write_cnt(1'b0, 4);
    write_cnt(1'b1, 3);
    enable = 1'b1;
    for (int i = 0; i < 4 + 3 + 6 + 5 + 4; i++) begin
      @(negedge clk);
      check_at(i, 4, 3, 6, 5, "R9 mid-phase write");
      if (i == 1) begin
        cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_data = 8'd6;
      end else if (i == 4) begin
        cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_data = 8'd5;
      end else begin
        cfg_wr = 1'b0;
      end
    end
    cfg_wr = 1'b0;
    stop_run();

    // R7: disable in the low phase returns scl high and holds it
    write_cnt(1'b0, 3);
    write_cnt(1'b1, 3);
    enable = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check_at(i, 3, 3, 3, 3, "R7 before disable");
    end
    enable = 1'b0;
    @(negedge clk);
    check_idle(1'b1, "R7 disable rise");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check_idle(1'b0, "R7 held high");
    end
    // R5: re-enable starts with low
    run_periodic(3, 3, 14, "R5 restart low first");

    // R8: soft reset while enabled, counts kept
    stop_run();
    write_cnt(1'b0, 5);
    write_cnt(1'b1, 2);
    enable = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_at(i, 5, 2, 5, 2, "R8 before soft reset");
    end
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    check_idle(1'b1, "R8 soft reset idle");
    run_periodic(5, 2, 16, "R8 counts kept after soft reset");
    stop_run();

    // random counts, including zero
    for (int t = 0; t < 24; t++) begin
      int lo, hi;
      lo = int'($urandom % 14);
      hi = int'($urandom % 14);
      write_cnt(1'b0, lo);
      write_cnt(1'b1, hi);
      run_periodic(lo, hi, 2 * (eff(lo) + eff(hi)) + 2, "R3 R4 random");
      stop_run();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule